// File: doc/BRIEF.md
# Host-to-DSP Byte-Assembly Transmit Channel

This block sits between a byte-wide host processor port and a DSP core that consumes 24-bit words. The host writes a word one byte at a time into three byte lanes (high, middle, low). Writing the low lane is the commit step: the assembled word then moves into a 24-bit DSP-side receive register as soon as that register is free. The DSP takes the word by pulsing a read strobe, which frees the register for the next word.

The host sees a byte-wide status register. It carries a transmit-empty flag, a transmitter-ready flag and two host flags that only the DSP side can change. A host request output tells the host that a new word may be written, provided the host has enabled requests. Hardware reset, software reset, individual reset and stop mode return the channel to its empty state. A host initialize command also marks the byte lanes as empty and abandons a word that is waiting.

Top module: `hxt_host_tx_channel`

## Requirements
- R1: After hardware reset (`rst_n` low at a clock edge) the status byte reads 8'h06, `dsp_rx_full` is 0 and `dsp_rx_data` is 0.
- R2: A host write with `host_sel` = 0 (the low lane) clears transmit-empty (status bit 1) at that clock edge. Writes with `host_sel` = 2 (high lane) or 1 (middle lane) leave transmit-empty unchanged.
- R3: When transmit-empty is 0, `dsp_rx_full` is 0 and no reset, stop or initialize is active, the next clock edge copies {high, middle, low} into `dsp_rx_data`, sets `dsp_rx_full` and sets transmit-empty. Words reach the DSP in the order the host commits them.
- R4: While `dsp_rx_full` is 1, a committed word waits and `dsp_rx_data` holds its value. A `dsp_rd` pulse clears `dsp_rx_full` at that edge, and the waiting word transfers on the following edge.
- R5: Transmitter-ready (status bit 2) equals transmit-empty AND NOT `dsp_rx_full` at all times. This status does not depend on `req_en`.
- R6: `host_req` equals transmit-empty AND `req_en`.
- R7: A cycle with `sw_reset`, `ind_reset` or `stop_mode` high sets transmit-empty and transmitter-ready and clears `dsp_rx_full` at that edge. A waiting word is dropped. While `stop_mode` is held, a low-lane write does not clear transmit-empty.
- R8: A `host_init` pulse sets transmit-empty at that edge. The word waiting in the byte lanes is then never transferred.
- R9: Status bit 3 shows DSP flag 0 and bit 4 shows DSP flag 1. A `dsp_flag_wr` pulse loads them from `dsp_flag_data[0]` and `dsp_flag_data[1]`. Hardware reset and software reset clear them. Individual reset and stop mode do not change them.
- R10: Status bits 0, 5, 6 and 7 always read 0.
- R11: A host write with `host_sel` = 3 selects no lane. It changes neither the byte lanes nor any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_reset | input | 1 | Software reset, synchronous, active high |
| ind_reset | input | 1 | Individual (channel-only) reset, active high |
| stop_mode | input | 1 | Stop mode; holds the channel in its empty state |
| host_init | input | 1 | Host initialize command pulse |
| host_wr | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Lane select: 0 low, 1 middle, 2 high, 3 none |
| host_wdata | input | 8 | Host write byte |
| req_en | input | 1 | Host request enable |
| dsp_flag_wr | input | 1 | DSP write strobe for the two host flags |
| dsp_flag_data | input | 2 | DSP flag values (bit 0 and bit 1) |
| dsp_rd | input | 1 | DSP read of the receive register |
| status_byte | output | 8 | Host status register |
| host_req | output | 1 | Host request output |
| dsp_rx_data | output | 24 | DSP-side receive register |
| dsp_rx_full | output | 1 | DSP-side receive register holds an unread word |

## Verification
The properties assume that the reset, stop and initialize inputs are synchronous to `clk` and that the host writes at most one lane per cycle. They also assume that `dsp_rd` is raised only as a one-cycle pulse while `dsp_rx_full` is set. The bench drives every input at the falling edge. It raises `dsp_rd` only after it has seen `dsp_rx_full` high, and never overlaps a low-lane write with an initialize or reset pulse. The DSP side is drained either by an automatic monitor or by explicit read pulses, so that the waiting-word case can be held open for several cycles.

// File: rtl/hxt_pkg.sv
// Package: hxt_pkg
// Shared constants for the host transmit channel: status bit positions
// and the status byte type. Assumes an 8-bit host status register.
package hxt_pkg;
    localparam int STATUS_W   = 8;
    localparam int ST_TE      = 1;  // transmit-empty
    localparam int ST_TRDY    = 2;  // transmitter-ready
    localparam int ST_HF_BASE = 3;  // first DSP-owned host flag
    localparam int ST_HF_MAX  = 2;  // flags fit below reserved bit 5

    typedef logic [STATUS_W-1:0] status_t;
endpackage

// File: rtl/hxt_byte_stage.sv
// Module: hxt_byte_stage
// Holds the host-written byte lanes and the transmit-empty flag.
// Lane 0 is the low byte; writing it commits the word. Assumes flush,
// host_init and xfer are synchronous and that xfer is only raised by the
// parent when transmit-empty is clear and the DSP register is free.
module hxt_byte_stage #(
    parameter  int BYTE_W  = 8,
    parameter  int N_BYTES = 3,
    localparam int WORD_W  = BYTE_W * N_BYTES,
    localparam int SEL_W   = $clog2(N_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              host_init,
    input  logic              host_wr,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              xfer,
    output logic [WORD_W-1:0] word_out,
    output logic              tx_empty
);
    logic [N_BYTES-1:0][BYTE_W-1:0] lanes;
    logic                           low_wr;

    // Commit strobe: a write aimed at the low lane.
    assign low_wr = host_wr && (host_sel == '0);

    genvar gi;
    generate
        for (gi = 0; gi < N_BYTES; gi++) begin : g_lane
            // Capture a host byte into this lane when it is selected.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lanes[gi] <= '0;
                end else if (host_wr && (host_sel == SEL_W'(gi))) begin
                    lanes[gi] <= host_wdata;
                end
            end
        end
    endgenerate

    // Transmit-empty: resets and init set it, a commit clears it, a transfer sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_empty <= 1'b1;
        end else if (flush) begin
            tx_empty <= 1'b1;
        end else if (host_init) begin
            tx_empty <= 1'b1;
        end else if (low_wr) begin
            tx_empty <= 1'b0;
        end else if (xfer) begin
            tx_empty <= 1'b1;
        end
    end

    assign word_out = lanes;
endmodule

// File: rtl/hxt_dsp_rx.sv
// Module: hxt_dsp_rx
// DSP-side receive register and its full flag. Loads on xfer, frees on a
// DSP read. Assumes xfer is never raised while full is set.
module hxt_dsp_rx #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              xfer,
    input  logic [WORD_W-1:0] word_in,
    input  logic              dsp_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full
);
    // Data register: loaded only by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (xfer) begin
            rx_data <= word_in;
        end
    end

    // Full flag: a transfer sets it, a DSP read or any reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
        end else if (flush) begin
            rx_full <= 1'b0;
        end else if (xfer) begin
            rx_full <= 1'b1;
        end else if (dsp_rd) begin
            rx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/hxt_flag_mirror.sv
// Module: hxt_flag_mirror
// DSP-owned host flags that the host sees read-only. Cleared by hardware
// and software reset only. Assumes dsp_flag_wr is synchronous.
module hxt_flag_mirror #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_reset,
    input  logic               flag_wr,
    input  logic [N_FLAGS-1:0] flag_data,
    output logic [N_FLAGS-1:0] flags
);
    // Flag register: DSP writes load it, hardware/software reset clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (sw_reset) begin
            flags <= '0;
        end else if (flag_wr) begin
            flags <= flag_data;
        end
    end
endmodule

// File: rtl/hxt_status.sv
// Module: hxt_status
// Builds the host status byte and the host request output from channel
// state. Purely combinational. Assumes N_FLAGS <= ST_HF_MAX so that the
// reserved bits stay zero.
module hxt_status
    import hxt_pkg::*;
#(
    parameter int N_FLAGS = 2
) (
    input  logic               tx_empty,
    input  logic               rx_full,
    input  logic               req_en,
    input  logic [N_FLAGS-1:0] flags,
    output status_t            status_byte,
    output logic               host_req
);
    // Status assembly: unused positions default to zero.
    always_comb begin
        status_byte          = '0;
        status_byte[ST_TE]   = tx_empty;
        status_byte[ST_TRDY] = tx_empty & ~rx_full;
        for (int i = 0; i < N_FLAGS; i++) begin
            status_byte[ST_HF_BASE + i] = flags[i];
        end
    end

    // Request: empty lanes gated by the host's enable.
    assign host_req = tx_empty & req_en;
endmodule

// File: rtl/hxt_host_tx_channel.sv
// Module: hxt_host_tx_channel
// Top of the host-to-DSP transmit channel. Three byte writes assemble a
// word that moves into the DSP receive register when that register is
// free. Assumes all control inputs are synchronous to clk.
module hxt_host_tx_channel
    import hxt_pkg::*;
#(
    parameter  int BYTE_W  = 8,
    parameter  int N_BYTES = 3,
    parameter  int N_FLAGS = 2,
    localparam int WORD_W  = BYTE_W * N_BYTES,
    localparam int SEL_W   = $clog2(N_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_reset,
    input  logic                ind_reset,
    input  logic                stop_mode,
    input  logic                host_init,
    input  logic                host_wr,
    input  logic [SEL_W-1:0]    host_sel,
    input  logic [BYTE_W-1:0]   host_wdata,
    input  logic                req_en,
    input  logic                dsp_flag_wr,
    input  logic [N_FLAGS-1:0]  dsp_flag_data,
    input  logic                dsp_rd,
    output logic [STATUS_W-1:0] status_byte,
    output logic                host_req,
    output logic [WORD_W-1:0]   dsp_rx_data,
    output logic                dsp_rx_full
);
    logic              flush;
    logic              xfer;
    logic              tx_empty;
    logic [WORD_W-1:0] word;
    logic [N_FLAGS-1:0] flags;

    // Any of the channel-emptying conditions.
    assign flush = sw_reset | ind_reset | stop_mode;

    // Transfer when a committed word waits and the DSP register is free.
    assign xfer = ~tx_empty & ~dsp_rx_full & ~flush & ~host_init;

    hxt_byte_stage #(
        .BYTE_W  (BYTE_W),
        .N_BYTES (N_BYTES)
    ) u_bytes (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .host_init  (host_init),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .xfer       (xfer),
        .word_out   (word),
        .tx_empty   (tx_empty)
    );

    hxt_dsp_rx #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .xfer    (xfer),
        .word_in (word),
        .dsp_rd  (dsp_rd),
        .rx_data (dsp_rx_data),
        .rx_full (dsp_rx_full)
    );

    hxt_flag_mirror #(
        .N_FLAGS (N_FLAGS)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_reset  (sw_reset),
        .flag_wr   (dsp_flag_wr),
        .flag_data (dsp_flag_data),
        .flags     (flags)
    );

    hxt_status #(
        .N_FLAGS (N_FLAGS)
    ) u_status (
        .tx_empty    (tx_empty),
        .rx_full     (dsp_rx_full),
        .req_en      (req_en),
        .flags       (flags),
        .status_byte (status_byte),
        .host_req    (host_req)
    );
endmodule

// File: rtl/hxt_host_tx_channel_chk.sv
// Module: hxt_host_tx_channel_chk
// Property checker for the transmit channel, bound to the top module.
// Observes ports only. Assumes the default two-flag status layout.
module hxt_host_tx_channel_chk #(
    parameter int N_BYTES = 3,
    parameter int SEL_W   = 2,
    parameter int WORD_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_reset,
    input logic              ind_reset,
    input logic              stop_mode,
    input logic              host_init,
    input logic              host_wr,
    input logic [SEL_W-1:0]  host_sel,
    input logic              req_en,
    input logic              dsp_flag_wr,
    input logic              dsp_rd,
    input logic [7:0]        status_byte,
    input logic              host_req,
    input logic [WORD_W-1:0] dsp_rx_data,
    input logic              dsp_rx_full
);
    logic any_flush;
    logic low_wr;
    logic none_wr;

    assign any_flush = sw_reset | ind_reset | stop_mode;
    assign low_wr    = host_wr && (host_sel == '0);
    assign none_wr   = host_wr && (int'(host_sel) >= N_BYTES);

    assert_low_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (low_wr && !any_flush && !host_init) |=> !status_byte[1]);

    assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_byte[1] && !dsp_rx_full && !any_flush && !host_init && !low_wr)
        |=> (dsp_rx_full && status_byte[1]));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_rx_full && !dsp_rd && !any_flush)
        |=> (dsp_rx_full && $stable(dsp_rx_data)));

    assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[2] == (status_byte[1] && !dsp_rx_full));

    assert_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_req == (status_byte[1] && req_en));

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_flush |=> (status_byte[2:1] == 2'b11 && !dsp_rx_full));

    assert_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_init && !any_flush) |=> status_byte[1]);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (status_byte[4:3] == 2'b00));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[0] == 1'b0) && (status_byte[7:5] == 3'b000));

    assert_no_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (none_wr && status_byte[1] && !any_flush && !host_init && !dsp_rd && !dsp_flag_wr)
        |=> $stable(status_byte));
endmodule

bind hxt_host_tx_channel hxt_host_tx_channel_chk #(
    .N_BYTES (N_BYTES),
    .SEL_W   (SEL_W),
    .WORD_W  (WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_reset    (sw_reset),
    .ind_reset   (ind_reset),
    .stop_mode   (stop_mode),
    .host_init   (host_init),
    .host_wr     (host_wr),
    .host_sel    (host_sel),
    .req_en      (req_en),
    .dsp_flag_wr (dsp_flag_wr),
    .dsp_rd      (dsp_rd),
    .status_byte (status_byte),
    .host_req    (host_req),
    .dsp_rx_data (dsp_rx_data),
    .dsp_rx_full (dsp_rx_full)
);

// File: tb/hxt_host_tx_channel_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes each committed word into a queue; a
// monitor drains the DSP side and compares in order.
module hxt_host_tx_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_reset = 1'b0, ind_reset = 1'b0, stop_mode = 1'b0;
    logic        host_init = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd3;
    logic [7:0]  host_wdata = 8'h00;
    logic        req_en = 1'b0;
    logic        dsp_flag_wr = 1'b0;
    logic [1:0]  dsp_flag_data = 2'b00;
    logic        mon_rd = 1'b0, man_rd = 1'b0, dsp_rd;
    logic [7:0]  status_byte;
    logic        host_req;
    logic [23:0] dsp_rx_data;
    logic        dsp_rx_full;

    int          checks = 0;
    int          failures = 0;
    logic        auto_drain = 1'b0;
    logic        done = 1'b0;
    logic [23:0] exp_q[$];

    assign dsp_rd = mon_rd | man_rd;

    always #2.5 clk = ~clk;

    hxt_host_tx_channel u_hxt_host_tx_channel (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .ind_reset(ind_reset),
        .stop_mode(stop_mode), .host_init(host_init), .host_wr(host_wr),
        .host_sel(host_sel), .host_wdata(host_wdata), .req_en(req_en),
        .dsp_flag_wr(dsp_flag_wr), .dsp_flag_data(dsp_flag_data), .dsp_rd(dsp_rd),
        .status_byte(status_byte), .host_req(host_req),
        .dsp_rx_data(dsp_rx_data), .dsp_rx_full(dsp_rx_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected word whenever the DSP register fills.
    always @(negedge clk) begin
        if (auto_drain && dsp_rx_full && !mon_rd) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected word", dsp_rx_data, 32'hFFFF_FFFF);
            end else begin
                chk("R3 scoreboard word", dsp_rx_data, exp_q.pop_front());
            end
            mon_rd <= 1'b1;
        end else begin
            mon_rd <= 1'b0;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 2'd3;
    endtask

    // Driver: writes high, middle, low; optionally queues the expected word.
    task automatic send_word(input logic [23:0] w, input bit to_sb);
        wr_byte(2'd2, w[23:16]);
        chk("R2 high write keeps empty", {31'd0, status_byte[1]}, 32'd1);
        wr_byte(2'd1, w[15:8]);
        if (to_sb) exp_q.push_back(w);
        wr_byte(2'd0, w[7:0]);
        chk("R2 low write clears empty", {31'd0, status_byte[1]}, 32'd0);
        chk("R6 request drops", {31'd0, host_req}, {31'd0, req_en & 1'b0});
    endtask

    task automatic dsp_read();
        @(negedge clk); man_rd = 1'b1;
        @(negedge clk); man_rd = 1'b0;
    endtask

    task automatic drain_wait();
        for (int i = 0; i < 50; i++) begin
            if (exp_q.size() == 0 && !dsp_rx_full && !mon_rd) break;
            @(negedge clk);
        end
        chk("R3 scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic pulse_kind(input int kind);
        @(negedge clk);
        case (kind)
            0: sw_reset = 1'b1;
            1: ind_reset = 1'b1;
            default: stop_mode = 1'b1;
        endcase
        @(negedge clk);
        sw_reset = 1'b0; ind_reset = 1'b0; stop_mode = 1'b0;
    endtask

    task automatic set_flags(input logic [1:0] d);
        @(negedge clk); dsp_flag_wr = 1'b1; dsp_flag_data = d;
        @(negedge clk); dsp_flag_wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        tick(20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state, R10 reserved bits, R6 request off
        chk("R1 status after reset", status_byte, 32'h06);
        chk("R1 rx full after reset", dsp_rx_full, 0);
        chk("R1 rx data after reset", dsp_rx_data, 0);
        chk("R6 request disabled", host_req, 0);
        req_en = 1'b1;
        tick(1);
        chk("R6 request enabled", host_req, 1);

        // R3 several words through the scoreboard
        auto_drain = 1'b1;
        send_word(24'hA5_5A_C3, 1'b1);
        send_word(24'h00_FF_01, 1'b1);
        send_word(24'hFF_00_80, 1'b1);
        drain_wait();
        // R11 select code 3 writes nothing
        wr_byte(2'd2, 8'h12);
        wr_byte(2'd1, 8'h34);
        wr_byte(2'd3, 8'hEE);
        chk("R11 no-lane write keeps flags", status_byte, 32'h06);
        exp_q.push_back(24'h12_34_56);
        wr_byte(2'd0, 8'h56);
        drain_wait();
        auto_drain = 1'b0;
        tick(2);

        // R4 waiting word while the DSP register is full
        send_word(24'h11_22_33, 1'b0);
        tick(1);
        chk("R3 word lands", dsp_rx_data, 32'h11_22_33);
        chk("R5 ready low when full", status_byte[2], 0);
        chk("R3 empty set after transfer", status_byte[1], 1);
        send_word(24'h44_55_66, 1'b0);
        tick(4);
        chk("R4 data held while full", dsp_rx_data, 32'h11_22_33);
        chk("R4 word still waiting", status_byte[1], 0);
        dsp_read();
        chk("R4 read frees register", dsp_rx_full, 0);
        chk("R5 ready low with waiting word", status_byte[2], 0);
        tick(1);
        chk("R4 waiting word transfers", dsp_rx_data, 32'h44_55_66);
        chk("R4 full after late transfer", dsp_rx_full, 1);
        dsp_read();
        chk("R5 ready high when all empty", status_byte[2], 1);

        // R8 initialize abandons the waiting word
        send_word(24'h77_88_99, 1'b0);
        tick(1);
        send_word(24'hAB_CD_EF, 1'b0);
        @(negedge clk); host_init = 1'b1;
        @(negedge clk); host_init = 1'b0;
        chk("R8 init sets empty", status_byte[1], 1);
        chk("R8 ready low while full", status_byte[2], 0);
        dsp_read();
        tick(3);
        chk("R8 abandoned word not sent", dsp_rx_full, 0);
        chk("R8 data unchanged", dsp_rx_data, 32'h77_88_99);

        // R7 software, individual reset and stop each empty the channel
        for (int k = 0; k < 3; k++) begin
            send_word(24'h010203 + k, 1'b0);
            tick(1);
            send_word(24'h0A0B0C + k, 1'b0);
            pulse_kind(k);
            chk("R7 flush sets empty and ready", status_byte[2:1], 32'h3);
            chk("R7 flush clears full", dsp_rx_full, 0);
            tick(2);
            chk("R7 dropped word stays dropped", dsp_rx_full, 0);
        end
        @(negedge clk); stop_mode = 1'b1;
        wr_byte(2'd0, 8'h5C);
        chk("R7 stop ignores commit", status_byte[1], 1);
        @(negedge clk); stop_mode = 1'b0;
        tick(2);
        chk("R7 no transfer after stop", dsp_rx_full, 0);

        // R9 flags mirror, survive individual reset and stop
        set_flags(2'b01);
        chk("R9 flag 0 at bit 3", status_byte[4:3], 32'h1);
        set_flags(2'b11);
        pulse_kind(1);
        chk("R9 individual reset keeps flags", status_byte[4:3], 32'h3);
        pulse_kind(2);
        chk("R9 stop keeps flags", status_byte[4:3], 32'h3);
        pulse_kind(0);
        chk("R9 software reset clears flags", status_byte[4:3], 32'h0);
        set_flags(2'b10);
        chk("R9 flag 1 at bit 4", status_byte, 32'h16);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R9 hardware reset clears flags", status_byte, 32'h06);
        chk("R10 reserved bits zero", {status_byte[7:5], status_byte[0]}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule